// File: doc/BRIEF.md
# RC5 Key Expansion Unit

This block turns a 128-bit secret key into the table of 32-bit round keys used by an RC5 cipher core that has 2r+2 subkeys. Software or an upstream loader presents the key as four 32-bit words, one per load strobe. After the fourth word the unit runs on its own in two phases. First it fills the round-key table with an arithmetic progression built from two fixed 32-bit constants. It then runs the mixing loop, which combines the key words into that table with additions and data-dependent rotations.

Each mixing iteration takes one clock. Both the round-key table and the key-word table are single-port memories with asynchronous read, and each is accessed once per cycle. When the schedule is complete the unit raises a ready flag. A cipher core can then apply any table index and read the addressed round key combinationally in the same cycle. Loading a new key while ready is high starts the whole schedule again.

Top module: `rc5_key_sched`

## Requirements
- R1: While reset is high, and at every clock after it, `ready` is 0 and `roundKey` is 0. This holds until four new key words have been loaded and the full schedule has run. Reset clears the word counter, the A and B registers and the phase.
- R2: Key words are taken on rising edges where `keyWrite` is 1, and they fill key slots 0, 1, 2 and 3 in arrival order. Idle cycles between the words do not change the result.
- R3: After completion, entry k of the table, for k = 0 .. 2r+1, equals the RC5 schedule, computed as follows. The table is first filled with S[0] = 0xB7E15163 and S[k] = S[k-1] + 0x9E3779B9 (mod 2^32). Then 3·(2r+2) iterations run, starting from A = B = 0 and i = j = 0. Each iteration sets A = rotl(S[i]+A+B, 3) and stores it in S[i]. It then sets B = rotl(L[j]+A+B, (A+B) mod 32) and stores it in L[j]. Finally i advances mod 2r+2 and j advances mod 4.
- R4: `ready` rises exactly 4·(2r+2) clock edges after the edge that takes the fourth key word (104 by default). It then stays high for as long as `keyWrite` stays 0.
- R5: `keyWrite` pulses while the fill or mix phase is running are ignored. The finished table is the one produced by the key loaded before the run began.
- R6: While `ready` is 1, `roundKey` shows table entry `keyIndex` in the same cycle the index is applied, with no clock edge in between. An index of 2r+2 or above returns 0.
- R7: A `keyWrite` pulse while `ready` is 1 clears `ready` at that edge and becomes key word 0 of a new load.
- R8: While the fill or mix phase runs, `ready` is 0 and `roundKey` is 0 for any index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| keyWrite | input | 1 | Load strobe for one key word |
| keyWord | input | 32 | Key word taken when keyWrite is 1 |
| keyIndex | input | $clog2(2·ROUNDS+2) | Round-key table index for lookup |
| roundKey | output | 32 | Addressed round key once ready, else 0 |
| ready | output | 1 | Schedule complete and table readable |

## Verification
The schedule is run with three keys: all zeros, a distinct nibble pattern and all ones. Because the rotate amounts in the mix loop depend on the data, these keys drive very different rotate sequences. A wrong rotate source, a swapped word order or an off-by-one iteration count therefore shows up in the table. The pattern key is loaded with idle gaps between words, to separate "load on strobe" from "load on consecutive cycles". The all-ones key is loaded while junk strobes arrive during the run, which tells the required ignore behaviour apart from a late overwrite of the key slots. A reset in the middle of a run, followed by a fresh load, confirms that nothing stale starts the schedule. A reload taken from the ready state confirms both the restart and the clearing of ready.

// File: rtl/rc5_pkg.sv
package rc5_pkg;

  localparam logic [31:0] MAGIC_P = 32'hB7E15163;
  localparam logic [31:0] MAGIC_Q = 32'h9E3779B9;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_FILL = 2'd1,
    PH_MIX  = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWr;   // write incoming key word into key slot
    logic clearAB;  // fourth word taken: restart A, B and progression
    logic fillWr;   // write progression value into round-key table
    logic mixWr;    // one mixing iteration this cycle
    logic lookup;   // table is readable at the port
  } ctlStrobes_t;

  function automatic logic [31:0] rotl32(input logic [31:0] x, input logic [4:0] sh);
    logic [63:0] t;
    t = {x, x} << sh;
    return t[63:32];
  endfunction

endpackage

// File: rtl/rc5_ctrl.sv
module rc5_ctrl
  import rc5_pkg::*;
#(
  parameter int T  = 26,
  parameter int IW = 5,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          keyWrite,
  input  logic [IW-1:0] keyIndex,
  output ctlStrobes_t   ctl,
  output logic [IW-1:0] sAddr,
  output logic [1:0]    lAddr,
  output logic          ready
);

  localparam logic [IW-1:0] LAST_IDX  = IW'(T - 1);
  localparam logic [CW-1:0] LAST_ITER = CW'(3 * T - 1);

  phase_t        phase;
  logic [1:0]    wordCnt;
  logic [IW-1:0] tabIdx;
  logic [1:0]    keyIdx;
  logic [CW-1:0] iterCnt;
  logic          takeWord;

  assign takeWord = keyWrite && (phase == PH_LOAD || phase == PH_DONE);

  always_comb begin
    ctl         = '0;
    ctl.loadWr  = takeWord;
    ctl.clearAB = takeWord && (wordCnt == 2'd3);
    ctl.fillWr  = (phase == PH_FILL);
    ctl.mixWr   = (phase == PH_MIX);
    ctl.lookup  = (phase == PH_DONE);
  end

  always_comb begin
    case (phase)
      PH_DONE: sAddr = keyIndex;
      default: sAddr = tabIdx;
    endcase
    lAddr = (phase == PH_MIX) ? keyIdx : wordCnt;
  end

  assign ready = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_LOAD;
      wordCnt <= '0;
      tabIdx  <= '0;
      keyIdx  <= '0;
      iterCnt <= '0;
    end else begin
      case (phase)
        PH_LOAD, PH_DONE: begin
          if (takeWord) begin
            wordCnt <= wordCnt + 2'd1;
            if (wordCnt == 2'd3) begin
              phase  <= PH_FILL;
              tabIdx <= '0;
            end else begin
              phase <= PH_LOAD;
            end
          end
        end
        PH_FILL: begin
          if (tabIdx == LAST_IDX) begin
            phase   <= PH_MIX;
            tabIdx  <= '0;
            keyIdx  <= '0;
            iterCnt <= '0;
          end else begin
            tabIdx <= tabIdx + 1'b1;
          end
        end
        PH_MIX: begin
          tabIdx  <= (tabIdx == LAST_IDX) ? '0 : tabIdx + 1'b1;
          keyIdx  <= keyIdx + 2'd1;
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST_ITER) begin
            phase   <= PH_DONE;
            wordCnt <= '0;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/rc5_datapath.sv
module rc5_datapath
  import rc5_pkg::*;
#(
  parameter int T  = 26,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  ctlStrobes_t   ctl,
  input  logic [IW-1:0] sAddr,
  input  logic [1:0]    lAddr,
  input  logic [31:0]   keyWord,
  output logic [31:0]   roundKey
);

  logic [31:0] sMem [0:T-1];
  logic [31:0] lMem [0:3];
  logic [31:0] regA, regB, regR;

  logic        sInRange;
  logic [31:0] sRd, lRd, aNext, bNext;
  logic [4:0]  rotAmt;

  // Single read port per memory, asynchronous
  always_comb begin
    sInRange = (int'(sAddr) < T);
    sRd      = sInRange ? sMem[sAddr] : '0;
    lRd      = lMem[lAddr];
  end

  always_comb begin
    aNext  = rotl32(sRd + regA + regB, 5'd3);
    rotAmt = aNext[4:0] + regB[4:0];
    bNext  = rotl32(lRd + aNext + regB, rotAmt);
  end

  assign roundKey = (ctl.lookup && sInRange) ? sRd : '0;

  always_ff @(posedge clk) begin
    if (ctl.fillWr && sInRange) sMem[sAddr] <= regR;
    else if (ctl.mixWr && sInRange) sMem[sAddr] <= aNext;
  end

  always_ff @(posedge clk) begin
    if (ctl.loadWr) lMem[lAddr] <= keyWord;
    else if (ctl.mixWr) lMem[lAddr] <= bNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
      regR <= MAGIC_P;
    end else if (ctl.clearAB) begin
      regA <= '0;
      regB <= '0;
      regR <= MAGIC_P;
    end else begin
      if (ctl.fillWr) regR <= regR + MAGIC_Q;
      if (ctl.mixWr) begin
        regA <= aNext;
        regB <= bNext;
      end
    end
  end

endmodule

// File: rtl/rc5_key_sched.sv
module rc5_key_sched
  import rc5_pkg::*;
#(
  parameter int ROUNDS = 12
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                keyWrite,
  input  logic [31:0]                         keyWord,
  input  logic [$clog2(2*ROUNDS+2)-1:0]       keyIndex,
  output logic [31:0]                         roundKey,
  output logic                                ready
);

  localparam int T  = 2 * ROUNDS + 2;
  localparam int IW = $clog2(T);
  localparam int CW = $clog2(3 * T);

  ctlStrobes_t   ctlS;
  logic [IW-1:0] sAddr;
  logic [1:0]    lAddr;

  rc5_ctrl #(.T(T), .IW(IW), .CW(CW)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .keyWrite (keyWrite),
    .keyIndex (keyIndex),
    .ctl      (ctlS),
    .sAddr    (sAddr),
    .lAddr    (lAddr),
    .ready    (ready)
  );

  rc5_datapath #(.T(T), .IW(IW)) uDp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctlS),
    .sAddr    (sAddr),
    .lAddr    (lAddr),
    .keyWord  (keyWord),
    .roundKey (roundKey)
  );

endmodule

// File: rtl/rc5_key_sched_chk.sv
module rc5_key_sched_chk
  import rc5_pkg::*;
#(
  parameter int T  = 26,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          keyWrite,
  input logic [IW-1:0] keyIndex,
  input logic [31:0]   roundKey,
  input logic          ready,
  input ctlStrobes_t   ctl
);

  logic [15:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst || ctl.clearAB) busyCnt <= '0;
    else if (!ready && busyCnt != 16'hFFFF) busyCnt <= busyCnt + 16'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!ready && roundKey == '0));

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (busyCnt == 16'(4 * T)));

  p_ready_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ready && !keyWrite) |=> ready);

  p_busy_no_load_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.fillWr || ctl.mixWr) |-> !ctl.loadWr);

  p_oob_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(keyIndex) >= T) |-> (roundKey == '0));

  p_reload_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (ready && keyWrite) |=> !ready);

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.fillWr || ctl.mixWr) |-> (!ready && roundKey == '0));

  p_one_phase_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.fillWr, ctl.mixWr, ctl.lookup}));

endmodule

bind rc5_key_sched rc5_key_sched_chk #(.T(T), .IW(IW)) uChk (
  .clk      (clk),
  .rst      (rst),
  .keyWrite (keyWrite),
  .keyIndex (keyIndex),
  .roundKey (roundKey),
  .ready    (ready),
  .ctl      (ctlS)
);

// File: tb/sim_rc5_key_sched.sv
`timescale 1ns/1ps
module sim_rc5_key_sched;

  localparam int BR  = 12;
  localparam int BT  = 2 * BR + 2;
  localparam int BIW = $clog2(BT);

  typedef struct {
    int          idx;
    logic [31:0] val;
    string       req;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rst;
  logic           keyWrite;
  logic [31:0]    keyWord;
  logic [BIW-1:0] keyIndex;
  logic [31:0]    roundKey;
  logic           ready;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  rc5_key_sched #(.ROUNDS(BR)) u0 (
    .clk(clk), .rst(rst), .keyWrite(keyWrite), .keyWord(keyWord),
    .keyIndex(keyIndex), .roundKey(roundKey), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int s;
    s = n % 32;
    return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
  endfunction

  // Driver side: reference schedule pushed as expected items
  task automatic pushExpected(input logic [31:0] k0, k1, k2, k3);
    logic [31:0] sT [BT];
    logic [31:0] lT [4];
    logic [31:0] a, b;
    int i, j;
    lT[0] = k0; lT[1] = k1; lT[2] = k2; lT[3] = k3;
    sT[0] = 32'hB7E15163;
    for (int k = 1; k < BT; k++) sT[k] = sT[k-1] + 32'h9E3779B9;
    a = '0; b = '0; i = 0; j = 0;
    for (int n = 0; n < 3 * BT; n++) begin
      a = rl(sT[i] + a + b, 3);
      sT[i] = a;
      b = rl(lT[j] + a + b, int'((a + b) & 32'h1F));
      lT[j] = b;
      i = (i + 1) % BT;
      j = (j + 1) % 4;
    end
    for (int k = 0; k < BT; k++) expQ.push_back('{idx: k, val: sT[k], req: "R3"});
    for (int k = BT; k < (1 << BIW); k++) expQ.push_back('{idx: k, val: 32'h0, req: "R6"});
  endtask

  // Monitor side: same-cycle lookup, no clock edge between index and compare (R6)
  task automatic drainCheck();
    expItem_t it;
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      keyIndex = BIW'(it.idx);
      #1;
      chk(it.req, roundKey, it.val);
    end
  endtask

  task automatic writeWord(input logic [31:0] w);
    logic wasReady;
    wasReady = ready;
    keyWrite = 1'b1;
    keyWord  = w;
    @(negedge clk);
    keyWrite = 1'b0;
    if (wasReady) chk("R7", {31'b0, ready}, 32'h0);
  endtask

  task automatic runKey(input logic [31:0] k0, k1, k2, k3, input int gap, input bit noise);
    int cycles;
    writeWord(k0); repeat (gap) @(negedge clk);
    writeWord(k1); repeat (gap) @(negedge clk);
    writeWord(k2); repeat (gap) @(negedge clk);
    writeWord(k3);
    pushExpected(k0, k1, k2, k3);
    cycles = 0;
    while (!ready && cycles < 1000) begin
      if (noise && cycles < 4 * BT - 3) begin
        keyWrite = 1'b1;
        keyWord  = 32'hDEAD0000 ^ cycles;   // R5 junk during the run
      end else begin
        keyWrite = 1'b0;
      end
      if (cycles == 10 || cycles == 60) begin
        keyIndex = BIW'(3);
        #1;
        chk("R8", roundKey, 32'h0);
      end
      @(negedge clk);
      cycles++;
    end
    keyWrite = 1'b0;
    chk("R4", cycles, 4 * BT);
    drainCheck();
    repeat (5) @(negedge clk);
    chk("R4", {31'b0, ready}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; keyWrite = 1'b0; keyWord = '0; keyIndex = '0;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, ready}, 32'h0);
    chk("R1", roundKey, 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", {31'b0, ready}, 32'h0);

    // R3 zero key, back-to-back words
    runKey(32'h0, 32'h0, 32'h0, 32'h0, 0, 1'b0);
    // R2 R7 pattern key with gaps, reloaded from ready
    runKey(32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210, 3, 1'b0);
    // R5 all-ones key with junk strobes while busy
    runKey(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 1'b1);

    // R1 reset in mid-run
    writeWord(32'h11111111); writeWord(32'h22222222);
    writeWord(32'h33333333); writeWord(32'h44444444);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {31'b0, ready}, 32'h0);
    rst = 1'b0;
    repeat (150) @(negedge clk);
    chk("R1", {31'b0, ready}, 32'h0);
    keyIndex = '0;
    #1;
    chk("R1", roundKey, 32'h0);
    @(negedge clk);
    runKey(32'hA5A5A5A5, 32'h5A5A5A5A, 32'h0F0F0F0F, 32'hF0F0F0F0, 1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule